// File: doc/BRIEF.md
# Prescaled Capture Timer

This block keeps a 16-bit counter that runs freely from the bus clock. A power-of-two prescaler sits in front of the counter, so the counter advances once every 1, 4, 8 or 16 bus cycles. The counter wraps from all ones to zero. Each wrap raises an overflow flag, and that flag can drive an interrupt request. Three capture channels each take a single-cycle strobe. On its strobe, a channel records the counter value into its own 16-bit register.

Software uses a byte-wide register port with a combinational read path. Through this port it can read and write either byte of the counter, set the prescaler and the interrupt enable, read and clear the overflow flag, and read the capture registers. The prescaler choice is accepted only during a short window after reset. Once the window closes, it stays fixed until the next reset.

Top module: `cap_timer`

## Requirements
- R1: The counter increments by one on each completed prescaler period and wraps from 0xFFFF to 0x0000.
- R2: The control register at address 2 holds the prescaler select in bits 1:0 and the overflow interrupt enable in bit 7. Select 0 divides by 1, 1 by 4, 2 by 8 and 3 by 16. Reading it returns {enable, 5'b0, select}.
- R3: Writes to the prescaler select take effect only during the first 64 bus cycles after reset. A later control write leaves the select unchanged but still updates the enable bit.
- R4: The status register at address 3 has the overflow flag in bit 7. The flag sets on the cycle the counter wraps from 0xFFFF to 0x0000.
- R5: The overflow flag is write-one-to-clear. Writing 0 to bit 7 has no effect. If a wrap and a clear fall in the same cycle, the set wins.
- R6: The interrupt request is high while both the overflow flag and the enable are set. It stays high until the flag is cleared or the enable is dropped.
- R7: A strobe on capture channel c copies the counter value of that cycle into capture register c. The high byte is read at address 4+2c and the low byte at 5+2c. A channel without a strobe holds its value.
- R8: Counter bytes are at address 0 (high) and address 1 (low). Writing one byte replaces that byte and keeps the other. The write also restarts the prescaler phase, so the next increment comes one full prescaler period later.
- R9: If a capture strobe and a counter write fall in the same cycle, the capture records the counter value from before the write.
- R10: Reset clears the counter, the prescaler select (back to divide by 1), the enable, the overflow flag and all capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_addr | input | ADDR_W (4) | Register address for read and write |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cap_strobe | input | CAP_CH (3) | One single-cycle capture strobe per channel |
| irq | output | 1 | Overflow interrupt request, level |

## Verification
The bench covers all four prescaler settings and compares the counter against floor(elapsed/divider) on every cycle after a write restarts the phase. An off-by-one in the prescaler compare would show up as a counter that runs early or late. The bench writes the select after the 64-cycle window has closed. A design without the lock would change its rate there, and a design that drops the whole write would lose the enable bit. The bench also drives a capture strobe and a counter write in the same cycle, which exposes a design that records the newly written value. It writes zero to the overflow flag to catch a clear that ignores the written data. Finally, it writes single counter bytes, which exposes a design that zeroes the other byte.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
   localparam int A_CNT_HI   = 0;
   localparam int A_CNT_LO   = 1;
   localparam int A_CTRL     = 2;
   localparam int A_STATUS   = 3;
   localparam int A_CAP_BASE = 4;
   localparam int MAX_DIV    = 16;

   typedef logic [1:0] presc_sel_t;

   // divider ratio for a select code: 1, 4, 8, 16
   function automatic int unsigned presc_div(input presc_sel_t s);
      case (s)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction
endpackage

// File: rtl/cap_timer_presc.sv
module cap_timer_presc
   import cap_timer_pkg::*;
#(
   parameter int DIV_MAX = MAX_DIV
) (
   input  logic       clk,
   input  logic       rst_n,
   input  presc_sel_t sel,
   input  logic       restart,
   output logic       tick
);
   localparam int PRE_W = $clog2(DIV_MAX);

   if ((1 << PRE_W) != DIV_MAX || DIV_MAX < 16) begin : g_bad_div
      $error("DIV_MAX must be a power of two of at least 16");
   end

   logic [PRE_W-1:0] ph_q;
   logic [PRE_W-1:0] last;

   always_comb last = PRE_W'(presc_div(sel) - 1);

   // a phase beyond the last slot (after a select change) ends the period at once
   assign tick = (ph_q >= last);

   always_ff @(posedge clk) begin
      if (!rst_n)              ph_q <= '0;
      else if (restart || tick) ph_q <= '0;
      else                     ph_q <= ph_q + 1'b1;
   end

   AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (ph_q == '0)); // R8
endmodule

// File: rtl/cap_timer_count.sv
module cap_timer_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic [7:0]       wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   localparam int HALF = CNT_W / 2;

   if (CNT_W != 16) begin : g_bad_width
      $error("CNT_W must be 16 for the byte register map");
   end

   assign wrap = tick && !wr_hi && !wr_lo && (cnt_q == '1);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (wr_hi) cnt_q[CNT_W-1:HALF] <= wdata;
      else if (wr_lo) cnt_q[HALF-1:0] <= wdata;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_hi && !wr_lo) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_hi && !wr_lo) |=> $stable(cnt_q)); // R1
   AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (cnt_q[HALF-1:0] == $past(cnt_q[HALF-1:0]))); // R8
   AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (cnt_q[CNT_W-1:HALF] == $past(cnt_q[CNT_W-1:HALF]))); // R8
endmodule

// File: rtl/cap_timer_capture.sv
module cap_timer_capture #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      cap_q <= '0;
      else if (strobe) cap_q <= cnt;
   end

   AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> (cap_q == $past(cnt))); // R9
   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(cap_q)); // R7
endmodule

// File: rtl/cap_timer.sv
module cap_timer
   import cap_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int CAP_CH      = 3,
   parameter int LOCK_CYCLES = 64,
   parameter int ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [CAP_CH-1:0] cap_strobe,
   output logic              irq
);
   localparam int AGE_W = $clog2(LOCK_CYCLES + 1);

   if (A_CAP_BASE + 2 * CAP_CH > (1 << ADDR_W)) begin : g_bad_map
      $error("ADDR_W too small for CAP_CH capture channels");
   end
   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("LOCK_CYCLES must be positive");
   end

   // write decode
   logic wr_hi, wr_lo, wr_ctrl, wr_stat;
   assign wr_hi   = bus_wr && (bus_addr == ADDR_W'(A_CNT_HI));
   assign wr_lo   = bus_wr && (bus_addr == ADDR_W'(A_CNT_LO));
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STATUS));

   // select lock window
   logic [AGE_W-1:0] age_q;
   logic             locked;
   assign locked = (age_q == AGE_W'(LOCK_CYCLES));

   always_ff @(posedge clk) begin
      if (!rst_n)       age_q <= '0;
      else if (!locked) age_q <= age_q + 1'b1;
   end

   presc_sel_t sel_q;
   logic       ie_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         ie_q  <= 1'b0;
      end else if (wr_ctrl) begin
         ie_q <= bus_wdata[7];
         if (!locked) sel_q <= bus_wdata[1:0];
      end
   end

   // prescaler and counter
   logic             tick, wrap;
   logic [CNT_W-1:0] cnt;

   cap_timer_presc #(.DIV_MAX(MAX_DIV)) i_presc (
      .clk(clk), .rst_n(rst_n), .sel(sel_q),
      .restart(wr_hi || wr_lo), .tick(tick));

   cap_timer_count #(.CNT_W(CNT_W)) i_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_hi(wr_hi), .wr_lo(wr_lo),
      .wdata(bus_wdata), .cnt_q(cnt), .wrap(wrap));

   // overflow flag: set wins over clear
   logic ovf_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                       ovf_q <= 1'b0;
      else if (wrap)                    ovf_q <= 1'b1;
      else if (wr_stat && bus_wdata[7]) ovf_q <= 1'b0;
   end

   assign irq = ovf_q && ie_q;

   // capture channels
   logic [CNT_W-1:0] cap_val [CAP_CH];

   for (genvar c = 0; c < CAP_CH; c++) begin : g_cap
      cap_timer_capture #(.CNT_W(CNT_W)) i_cap (
         .clk(clk), .rst_n(rst_n), .strobe(cap_strobe[c]),
         .cnt(cnt), .cap_q(cap_val[c]));
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(A_CNT_HI): bus_rdata = cnt[CNT_W-1:8];
         ADDR_W'(A_CNT_LO): bus_rdata = cnt[7:0];
         ADDR_W'(A_CTRL):   bus_rdata = {ie_q, 5'b0, sel_q};
         ADDR_W'(A_STATUS): bus_rdata = {ovf_q, 7'b0};
         default: begin
            for (int c = 0; c < CAP_CH; c++) begin
               if (bus_addr == ADDR_W'(A_CAP_BASE + 2 * c))
                  bus_rdata = cap_val[c][CNT_W-1:8];
               if (bus_addr == ADDR_W'(A_CAP_BASE + 2 * c + 1))
                  bus_rdata = cap_val[c][7:0];
            end
         end
      endcase
   end

   AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(sel_q)); // R3
   AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_hi && !wr_lo && cnt == '1) |=> ovf_q); // R4
   AST_NO_SPURIOUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(wr_stat && bus_wdata[7])) |=> ovf_q); // R5
   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_stat && !wr_ctrl) |=> irq); // R6
endmodule

// File: tb/test_cap_timer.sv
module test_cap_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] cap_strobe = '0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cap_timer i_cap_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_strobe(cap_strobe), .irq(irq));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output int v);
      bus_addr = 4'(a);
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic rd_cnt(output int v);
      int h, l;
      rd(0, h);
      rd(1, l);
      v = (h << 8) | l;
   endtask

   task automatic rd_cap(input int c, output int v);
      int h, l;
      rd(4 + 2 * c, h);
      rd(5 + 2 * c, l);
      v = (h << 8) | l;
   endtask

   // called at a negedge, returns at the next negedge
   task automatic wr(input int a, input int d);
      bus_addr = 4'(a);
      bus_wdata = 8'(d);
      bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int v, l;
      // R10 reset state
      @(negedge clk);
      rd_cnt(v); check("R10 counter at reset", v, 0);
      rd(2, v);  check("R10 control at reset", v, 0);
      rd(3, v);  check("R10 status at reset", v, 0);
      check("R10 irq at reset", int'(irq), 0);

      // R1 R2 R8: sweep all prescaler settings
      for (int s = 0; s < 4; s++) begin
         int d;
         d = (s == 0) ? 1 : (1 << (s + 1));
         do_reset();
         wr(2, s);
         rd(2, v); check("R2 select readback", v, s);
         wr(0, 0);
         wr(1, 0);
         for (int k = 1; k <= 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            rd_cnt(v);
            check($sformatf("R1 R2 count div%0d k=%0d", d, k), v, k / d);
         end
      end

      // R8: byte writes keep the other byte (divide by 16 still active)
      rd(1, l);
      wr(0, 8'hAB);
      rd_cnt(v); check("R8 high write keeps low", v, (8'hAB << 8) | l);
      wr(1, 8'h5C);
      rd_cnt(v); check("R8 low write keeps high", v, 16'hAB5C);
      repeat (15) @(negedge clk);
      rd_cnt(v); check("R8 phase restart, 15 cycles", v, 16'hAB5C);
      @(negedge clk);
      rd_cnt(v); check("R8 phase restart, 16 cycles", v, 16'hAB5D);

      // R3: select is locked after the window
      repeat (70) @(negedge clk);
      wr(2, 8'h80);
      rd(2, v); check("R3 late write keeps select, sets enable", v, 8'h83);
      wr(2, 8'h01);
      rd(2, v); check("R3 late write clears enable only", v, 8'h03);

      // R10: reset returns select to divide by 1
      do_reset();
      rd(2, v); check("R10 select after reset", v, 0);

      // R4 R5 R6: overflow at divide by 1
      wr(0, 8'hFF);
      wr(1, 8'hFF);
      rd_cnt(v); check("R8 counter loaded all ones", v, 16'hFFFF);
      rd(3, v);  check("R4 no flag before wrap", v, 0);
      @(negedge clk);
      rd_cnt(v); check("R1 wrap to zero", v, 0);
      rd(3, v);  check("R4 flag after wrap", v, 8'h80);
      check("R6 irq low while disabled", int'(irq), 0);
      wr(2, 8'h80);
      check("R6 irq high once enabled", int'(irq), 1);
      wr(3, 8'h00);
      rd(3, v);  check("R5 zero write leaves flag", v, 8'h80);
      repeat (5) @(negedge clk);
      check("R6 irq held", int'(irq), 1);
      wr(3, 8'h80);
      rd(3, v);  check("R5 one write clears flag", v, 0);
      check("R6 irq drops with flag", int'(irq), 0);

      // R7: each channel on its own
      for (int c = 0; c < 3; c++) begin
         int exp, other;
         repeat (3 + c) @(negedge clk);
         rd_cnt(exp);
         cap_strobe = 3'(1 << c);
         @(posedge clk);
         @(negedge clk);
         cap_strobe = '0;
         repeat (2) @(negedge clk);
         rd_cap(c, v);
         check($sformatf("R7 channel %0d capture", c), v, exp);
         if (c > 0) begin
            rd_cap(0, other);
            check("R7 channel 0 holds", other == exp ? 1 : 0, 0);
         end
      end
      // R7: all three together
      rd_cnt(l);
      cap_strobe = 3'b111;
      @(posedge clk);
      @(negedge clk);
      cap_strobe = '0;
      for (int c = 0; c < 3; c++) begin
         rd_cap(c, v);
         check($sformatf("R7 joint capture ch%0d", c), v, l);
      end

      // R9: capture and counter write in the same cycle
      rd_cnt(l);
      cap_strobe = 3'b010;
      bus_addr = 4'd0;
      bus_wdata = 8'h12;
      bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      cap_strobe = '0;
      rd_cap(1, v); check("R9 capture takes value before write", v, l);
      rd(0, v);     check("R9 counter high written", v, 8'h12);

      // R10: reset with state present
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rd_cnt(v);    check("R10 counter cleared", v, 0);
      rd(2, v);     check("R10 control cleared", v, 0);
      for (int c = 0; c < 3; c++) begin
         rd_cap(c, v);
         check($sformatf("R10 capture %0d cleared", c), v, 0);
      end
      rst_n = 1'b1;

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule